// File: doc/BRIEF.md
# Power-Domain Gating Controller

This block switches a small set of power domains on and off under software control. Software first stores a bitmask in one of two select registers, one for domains to bring up and one for domains to shut down. It then writes a three-byte unlock sequence, one byte per write, to a single command register. A parser checks the bytes in order. Only a complete and correct sequence starts a switch. This keeps a stray write from cutting power to a running domain.

Once a sequence is accepted, a sequencer works through the selected domains one at a time, starting at the lowest index. For each domain it drives the power-enable output and waits for that domain's power-good input. If power-good does not arrive within a cycle budget, the sequencer restores the enable and records a failure. A read-only mode register shows which domains are powered. Software polls that register, or it waits for the interrupt, to learn that the work is finished. Domains 0 and 1 are permanently powered and never gated.

Top module: `pwr_domain_ctl`

## Requirements
- R1: After reset, `pwr_en_o` is 0x03, the mode register reads 0x03, the interrupt mask reads 0x1FF, the status register reads 0 and `irq_o` is 0.
- R2: The register map is as follows.
  - 0x0C: up-select, bits 6:0, read/write.
  - 0x10: down-select, bits 6:0, read/write.
  - 0x44: command; always reads 0.
  - 0x48: interrupt mask, bits 8:0.
  - 0x80: power mode, bits 6:0, read-only.
  - 0x8C: status, bits 8:0.
  - Any other address reads 0.
  - `bus_rdata` shows the register addressed in the previous cycle.
- R3: The command bytes 0xFF, 0x05, 0x50 in that order power up every domain that is set in up-select and is currently off.
- R4: The command bytes 0xFF, 0x0A, 0xA0 in that order power down every domain that is set in down-select and is currently on. Domains 0 and 1 are excluded, and their enables stay high at all times.
- R5: A 0xFF command byte returns the parser to its armed start state from any state, including partway through a sequence and the error state.
- R6: Any command byte that is not the expected next byte puts the parser in an error state and sets status bit 2. In the error state, every byte except 0xFF is ignored and switches nothing.
- R7: Domains switch one at a time in ascending index order. A domain's mode bit takes the new value only after its power-good input has matched the target state. At no time does more than one enable differ from its mode bit.
- R8: If power-good does not match within PG_TIMEOUT cycles, the sequencer does three things. It restores that domain's enable, leaves the domain's mode bit unchanged and sets status bit 3. It then moves on to the next domain.
- R9: Status bit 0 is set when a sequence finishes, including a sequence that had no domain to change.
- R10: A valid command that completes while a sequence is still running is ignored and sets status bit 2.
- R11: Writing 1 to a status bit clears it. Status bits 1 and 4 to 8 always read 0.
- R12: `irq_o` is the OR of the status bits whose mask bit is 0, one cycle after the status register. A mask bit of 1 disables that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pwr_en_o | output | NUM_DOM | Per-domain power enable |
| pwr_good_i | input | NUM_DOM | Per-domain power-good |
| irq_o | output | 1 | Interrupt request |

## Verification
A parser stuck in the wrong state shows up when a command is issued. Either a correct sequence fails to move `pwr_en_o` one cycle after its last byte, or a bad one moves it, or status bit 2 reads back wrongly. A wrong pending set or domain index in the sequencer shows on `pwr_en_o` within a cycle of the affected step, as a domain switched out of order or a second enable in flight at once. A lost or stuck status bit shows on `irq_o` one cycle later once it is unmasked, and on the next status read. The reference model is compared with the enables, the interrupt and the read data every cycle, so these faults are reported in the cycle they become visible.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  // parser states
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ARMED,
    PS_UP,
    PS_DN,
    PS_ERR
  } parse_st_t;

  // sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RUN,
    SQ_WAIT
  } seq_st_t;

  localparam int STAT_W     = 9;
  localparam int ST_DONE    = 0;
  localparam int ST_CMDFAIL = 2;
  localparam int ST_TMO     = 3;

  localparam logic [7:0] K_RESTART = 8'hFF;
  localparam logic [7:0] K_UP_LO   = 8'h05;
  localparam logic [7:0] K_UP_HI   = 8'h50;
  localparam logic [7:0] K_DN_LO   = 8'h0A;
  localparam logic [7:0] K_DN_HI   = 8'hA0;

  localparam logic [7:0] A_UPSEL = 8'h0C;
  localparam logic [7:0] A_DNSEL = 8'h10;
  localparam logic [7:0] A_CMD   = 8'h44;
  localparam logic [7:0] A_IMASK = 8'h48;
  localparam logic [7:0] A_MODE  = 8'h80;
  localparam logic [7:0] A_STAT  = 8'h8C;

endpackage

// File: rtl/pdc_cmd_parser.sv
module pdc_cmd_parser
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld,
  input  logic [7:0] byte_i,
  output logic       go_up,
  output logic       go_dn,
  output logic       bad_seq
);

  parse_st_t st_q, st_d;

  always_comb begin
    st_d    = st_q;
    go_up   = 1'b0;
    go_dn   = 1'b0;
    bad_seq = 1'b0;
    if (byte_vld) begin
      if (byte_i == K_RESTART) begin
        st_d = PS_ARMED;
      end else begin
        case (st_q)
          PS_ARMED: begin
            if (byte_i == K_UP_LO)      st_d = PS_UP;
            else if (byte_i == K_DN_LO) st_d = PS_DN;
            else begin
              st_d    = PS_ERR;
              bad_seq = 1'b1;
            end
          end
          PS_UP: begin
            if (byte_i == K_UP_HI) begin
              st_d  = PS_IDLE;
              go_up = 1'b1;
            end else begin
              st_d    = PS_ERR;
              bad_seq = 1'b1;
            end
          end
          PS_DN: begin
            if (byte_i == K_DN_HI) begin
              st_d  = PS_IDLE;
              go_dn = 1'b1;
            end else begin
              st_d    = PS_ERR;
              bad_seq = 1'b1;
            end
          end
          PS_IDLE: begin
            st_d    = PS_ERR;
            bad_seq = 1'b1;
          end
          default: st_d = PS_ERR;  // error: wait for restart byte
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PS_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/pdc_domain_seq.sv
module pdc_domain_seq
  import pdc_pkg::*;
#(
  parameter int                 NUM_DOM    = 7,
  parameter logic [NUM_DOM-1:0] AON_MASK   = 'h3,
  parameter int                 PG_TIMEOUT = 2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_up,
  input  logic               go_dn,
  input  logic [NUM_DOM-1:0] up_sel,
  input  logic [NUM_DOM-1:0] dn_sel,
  input  logic [NUM_DOM-1:0] pg,
  output logic [NUM_DOM-1:0] en,
  output logic [NUM_DOM-1:0] mode,
  output logic               done,
  output logic               tmo_fail,
  output logic               busy_rej
);

  localparam int IDX_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam int TMR_W = $clog2(PG_TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PG_TIMEOUT - 1);

  seq_st_t            st_q;
  logic               dir_q;
  logic [NUM_DOM-1:0] pend_q;
  logic [NUM_DOM-1:0] en_q;
  logic [NUM_DOM-1:0] mode_q;
  logic [IDX_W-1:0]   cur_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [IDX_W-1:0]   pick;
  logic               pg_hit;
  logic               tmr_end;

  // lowest pending domain index
  always_comb begin
    pick = '0;
    for (int i = NUM_DOM - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = IDX_W'(i);
    end
  end

  assign pg_hit  = (pg[cur_q] == dir_q);
  assign tmr_end = (tmr_q == TMR_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      dir_q  <= 1'b0;
      pend_q <= '0;
      en_q   <= AON_MASK;
      mode_q <= AON_MASK;
      cur_q  <= '0;
      tmr_q  <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (go_up || go_dn) begin
            dir_q  <= go_up;
            pend_q <= go_up ? (up_sel & ~mode_q)
                            : (dn_sel & mode_q & ~AON_MASK);
            st_q   <= SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (pend_q == '0) begin
            st_q <= SQ_IDLE;
          end else begin
            cur_q       <= pick;
            en_q[pick]  <= dir_q;
            tmr_q       <= '0;
            st_q        <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (pg_hit) begin
            mode_q[cur_q] <= dir_q;
            pend_q[cur_q] <= 1'b0;
            st_q          <= SQ_RUN;
          end else if (tmr_end) begin
            en_q[cur_q]   <= ~dir_q;
            pend_q[cur_q] <= 1'b0;
            st_q          <= SQ_RUN;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign en       = en_q;
  assign mode     = mode_q;
  assign done     = (st_q == SQ_RUN) && (pend_q == '0);
  assign tmo_fail = (st_q == SQ_WAIT) && !pg_hit && tmr_end;
  assign busy_rej = (go_up || go_dn) && (st_q != SQ_IDLE);

endmodule

// File: rtl/pdc_irq_ctl.sv
module pdc_irq_ctl #(
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set_ev,
  input  logic          clr_wr,
  input  logic [SW-1:0] clr_bits,
  input  logic          mask_wr,
  input  logic [SW-1:0] mask_wdata,
  output logic [SW-1:0] stat,
  output logic [SW-1:0] mask,
  output logic          irq
);

  logic [SW-1:0] stat_q, mask_q;
  logic          irq_q;
  logic [SW-1:0] clr_v;

  assign clr_v = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_ev;
      if (mask_wr) mask_q <= mask_wdata;
      irq_q  <= |(stat_q & ~mask_q);
    end
  end

  assign stat = stat_q;
  assign mask = mask_q;
  assign irq  = irq_q;

endmodule

// File: rtl/pwr_domain_ctl.sv
module pwr_domain_ctl
  import pdc_pkg::*;
#(
  parameter int                 NUM_DOM    = 7,
  parameter logic [NUM_DOM-1:0] AON_MASK   = 'h3,
  parameter int                 PG_TIMEOUT = 2000,
  parameter int                 ADDR_W     = 8,
  parameter int                 DATA_W     = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_DOM-1:0] pwr_en_o,
  input  logic [NUM_DOM-1:0] pwr_good_i,
  output logic               irq_o
);

  logic [NUM_DOM-1:0] up_sel_q, dn_sel_q;
  logic [NUM_DOM-1:0] cur_mode;
  logic [DATA_W-1:0]  rdata_q;
  logic [STAT_W-1:0]  irq_stat, irq_mask, set_ev;
  logic               hit_up, hit_dn, hit_cmd, hit_imask, hit_stat;
  logic               go_up, go_dn, bad_seq;
  logic               ev_done, ev_tmo, busy_rej, ev_cmdfail;
  logic               unused_wdata;

  assign hit_up    = bus_wr && (bus_addr == ADDR_W'(A_UPSEL));
  assign hit_dn    = bus_wr && (bus_addr == ADDR_W'(A_DNSEL));
  assign hit_cmd   = bus_wr && (bus_addr == ADDR_W'(A_CMD));
  assign hit_imask = bus_wr && (bus_addr == ADDR_W'(A_IMASK));
  assign hit_stat  = bus_wr && (bus_addr == ADDR_W'(A_STAT));
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_sel_q <= '0;
      dn_sel_q <= '0;
    end else begin
      if (hit_up) up_sel_q <= bus_wdata[NUM_DOM-1:0];
      if (hit_dn) dn_sel_q <= bus_wdata[NUM_DOM-1:0];
    end
  end

  pdc_cmd_parser u_parse (
    .clk     (clk),
    .rst     (rst),
    .byte_vld(hit_cmd),
    .byte_i  (bus_wdata[7:0]),
    .go_up   (go_up),
    .go_dn   (go_dn),
    .bad_seq (bad_seq)
  );

  pdc_domain_seq #(
    .NUM_DOM   (NUM_DOM),
    .AON_MASK  (AON_MASK),
    .PG_TIMEOUT(PG_TIMEOUT)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .go_up   (go_up),
    .go_dn   (go_dn),
    .up_sel  (up_sel_q),
    .dn_sel  (dn_sel_q),
    .pg      (pwr_good_i),
    .en      (pwr_en_o),
    .mode    (cur_mode),
    .done    (ev_done),
    .tmo_fail(ev_tmo),
    .busy_rej(busy_rej)
  );

  assign ev_cmdfail = bad_seq || busy_rej;

  always_comb begin
    set_ev             = '0;
    set_ev[ST_DONE]    = ev_done;
    set_ev[ST_CMDFAIL] = ev_cmdfail;
    set_ev[ST_TMO]     = ev_tmo;
  end

  pdc_irq_ctl #(
    .SW(STAT_W)
  ) u_irq (
    .clk       (clk),
    .rst       (rst),
    .set_ev    (set_ev),
    .clr_wr    (hit_stat),
    .clr_bits  (bus_wdata[STAT_W-1:0]),
    .mask_wr   (hit_imask),
    .mask_wdata(bus_wdata[STAT_W-1:0]),
    .stat      (irq_stat),
    .mask      (irq_mask),
    .irq       (irq_o)
  );

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      if (bus_addr == ADDR_W'(A_UPSEL))      rdata_q <= DATA_W'(up_sel_q);
      else if (bus_addr == ADDR_W'(A_DNSEL)) rdata_q <= DATA_W'(dn_sel_q);
      else if (bus_addr == ADDR_W'(A_IMASK)) rdata_q <= DATA_W'(irq_mask);
      else if (bus_addr == ADDR_W'(A_MODE))  rdata_q <= DATA_W'(cur_mode);
      else if (bus_addr == ADDR_W'(A_STAT))  rdata_q <= DATA_W'(irq_stat);
      else                                   rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/pdc_chk.sv
module pdc_chk
  import pdc_pkg::*;
#(
  parameter int                 NUM_DOM  = 7,
  parameter logic [NUM_DOM-1:0] AON_MASK = 'h3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_DOM-1:0] pwr_en,
  input logic [NUM_DOM-1:0] mode,
  input logic [NUM_DOM-1:0] pg,
  input logic [STAT_W-1:0]  stat,
  input logic [STAT_W-1:0]  imask,
  input logic               irq,
  input logic               cmdfail,
  input logic               done
);

  // R4
  aon_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_en & AON_MASK) == AON_MASK);

  // R7
  one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(pwr_en ^ mode) <= 1);

  // R7
  mode_after_pg_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode & ~$past(mode)) & ~$past(pg)) == '0);

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~imask) == '0) |=> !irq);

  // R12
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~imask) != '0) |=> irq);

  // R6
  cmdfail_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cmdfail |=> stat[ST_CMDFAIL]);

  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> stat[ST_DONE]);

endmodule

bind pwr_domain_ctl pdc_chk #(
  .NUM_DOM (NUM_DOM),
  .AON_MASK(AON_MASK)
) i_chk (
  .clk    (clk),
  .rst    (rst),
  .pwr_en (pwr_en_o),
  .mode   (cur_mode),
  .pg     (pwr_good_i),
  .stat   (irq_stat),
  .imask  (irq_mask),
  .irq    (irq_o),
  .cmdfail(ev_cmdfail),
  .done   (ev_done)
);

// File: tb/test_pwr_domain_ctl.sv
`timescale 1ns/1ps
module test_pwr_domain_ctl;

  localparam int       N    = 7;
  localparam bit [6:0] AON  = 7'h03;
  localparam int       TMO  = 16;
  localparam int       PLAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [6:0]  pwr_en;
  logic [6:0]  pg = 7'h03;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwr_domain_ctl #(
    .NUM_DOM(N), .AON_MASK(AON), .PG_TIMEOUT(TMO), .ADDR_W(8), .DATA_W(32)
  ) i_pwr_domain_ctl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en_o(pwr_en),
    .pwr_good_i(pg), .irq_o(irq)
  );

  // power switch model: power-good follows enable after PLAT cycles
  bit stuck [N];
  int pcnt [N];
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        pg[i] = AON[i];
        pcnt[i] = 0;
      end else if (pwr_en[i] != pg[i] && !stuck[i]) begin
        pcnt[i]++;
        if (pcnt[i] >= PLAT) begin
          pg[i] = pwr_en[i];
          pcnt[i] = 0;
        end
      end else begin
        pcnt[i] = 0;
      end
    end
  end

  // enable rise order monitor
  int rise_q[$];
  logic [6:0] en_prev = 7'h03;
  always @(negedge clk) begin
    for (int i = 0; i < N; i++)
      if (pwr_en[i] && !en_prev[i]) rise_q.push_back(i);
    en_prev = pwr_en;
  end

  // behavioural reference model
  int       pst;
  int       sst;
  int       pq[$];
  bit       mdir;
  int       mcur;
  int       mtmr;
  bit [6:0] m_en, m_mode, m_up, m_dn;
  bit [8:0] m_stat, m_mask;
  bit       m_irq;
  bit [31:0] m_rd;
  bit       live = 0;

  always @(posedge clk) begin
    if (rst) begin
      pst = 0; sst = 0; pq.delete(); mdir = 0; mcur = 0; mtmr = 0;
      m_en = AON; m_mode = AON; m_up = 0; m_dn = 0;
      m_stat = 0; m_mask = 9'h1FF; m_irq = 0; m_rd = 0;
      live = 0;
    end else begin
      bit [8:0] set_v, clr_v;
      bit fu, fd;
      bit [7:0] b;
      live = 1;
      set_v = 0; fu = 0; fd = 0;
      m_irq = |(m_stat & ~m_mask);
      case (bus_addr)
        8'h0C: m_rd = {25'd0, m_up};
        8'h10: m_rd = {25'd0, m_dn};
        8'h48: m_rd = {23'd0, m_mask};
        8'h80: m_rd = {25'd0, m_mode};
        8'h8C: m_rd = {23'd0, m_stat};
        default: m_rd = 0;
      endcase
      if (bus_wr && bus_addr == 8'h44) begin
        b = bus_wdata[7:0];
        if (b == 8'hFF) pst = 1;
        else if (pst == 1) begin
          if (b == 8'h05) pst = 2;
          else if (b == 8'h0A) pst = 3;
          else begin pst = 4; set_v[2] = 1; end
        end else if (pst == 2) begin
          if (b == 8'h50) begin pst = 0; fu = 1; end
          else begin pst = 4; set_v[2] = 1; end
        end else if (pst == 3) begin
          if (b == 8'hA0) begin pst = 0; fd = 1; end
          else begin pst = 4; set_v[2] = 1; end
        end else if (pst == 0) begin
          pst = 4; set_v[2] = 1;
        end
      end
      if (sst == 0) begin
        if (fu || fd) begin
          mdir = fu;
          for (int i = 0; i < N; i++) begin
            if (fu && m_up[i] && !m_mode[i]) pq.push_back(i);
            if (fd && m_dn[i] && m_mode[i] && !AON[i]) pq.push_back(i);
          end
          sst = 1;
        end
      end else begin
        if (fu || fd) set_v[2] = 1;
        if (sst == 1) begin
          if (pq.size() == 0) begin
            set_v[0] = 1; sst = 0;
          end else begin
            mcur = pq.pop_front(); m_en[mcur] = mdir; mtmr = 0; sst = 2;
          end
        end else begin
          if (pg[mcur] == mdir) begin
            m_mode[mcur] = mdir; sst = 1;
          end else if (mtmr == TMO - 1) begin
            m_en[mcur] = !mdir; set_v[3] = 1; sst = 1;
          end else mtmr++;
        end
      end
      clr_v = (bus_wr && bus_addr == 8'h8C) ? bus_wdata[8:0] : 9'h0;
      m_stat = (m_stat & ~clr_v) | set_v;
      if (bus_wr && bus_addr == 8'h0C) m_up = bus_wdata[6:0];
      if (bus_wr && bus_addr == 8'h10) m_dn = bus_wdata[6:0];
      if (bus_wr && bus_addr == 8'h48) m_mask = bus_wdata[8:0];
    end
  end

  // lockstep comparison every cycle (R7 sequencing, R12 interrupt, R2 read data)
  always @(negedge clk) begin
    if (live && !rst) begin
      n_chk++;
      if (pwr_en !== m_en || irq !== m_irq || bus_rdata !== m_rd) begin
        n_fail++;
        $display("FAIL R7 lockstep t=%0t act en=%h irq=%b rd=%h exp en=%h irq=%b rd=%h",
                 $time, pwr_en, irq, bus_rdata, m_en, m_irq, m_rd);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic cmd_up();
    wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h50);
  endtask

  task automatic cmd_dn();
    wr(8'h44, 32'hFF); wr(8'h44, 32'h0A); wr(8'h44, 32'hA0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int ord;
    for (int i = 0; i < N; i++) stuck[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pwr_en", {25'd0, pwr_en}, 32'h03);
    check("R1 irq", {31'd0, irq}, 32'h0);
    rd(8'h80, v); check("R1 mode", v, 32'h03);
    rd(8'h48, v); check("R1 imask", v, 32'h1FF);
    rd(8'h8C, v); check("R1 status", v, 32'h0);

    // R2 register map
    wr(8'h0C, 32'hFFFF_FF3C); rd(8'h0C, v); check("R2 upsel", v, 32'h3C);
    wr(8'h10, 32'h14);        rd(8'h10, v); check("R2 dnsel", v, 32'h14);
    rd(8'h44, v); check("R2 cmd reads 0", v, 32'h0);
    rd(8'h20, v); check("R2 unmapped", v, 32'h0);

    // R3 power-up, R7 order, R9 done flag
    rise_q.delete();
    cmd_up();
    repeat (80) @(negedge clk);
    rd(8'h80, v); check("R3 mode after up", v, 32'h3F);
    check("R3 pwr_en after up", {25'd0, pwr_en}, 32'h3F);
    ord = 0;
    foreach (rise_q[k]) ord = ord * 10 + rise_q[k];
    check("R7 ascending order", ord, 2345);
    rd(8'h8C, v); check("R9 done bit", v, 32'h001);

    // R11 write-one-to-clear
    wr(8'h8C, 32'h1); rd(8'h8C, v); check("R11 w1c", v, 32'h0);

    // R4 power-down, always-on kept
    wr(8'h10, 32'h7F);
    cmd_dn();
    repeat (80) @(negedge clk);
    rd(8'h80, v); check("R4 mode after down", v, 32'h03);
    check("R4 pwr_en after down", {25'd0, pwr_en}, 32'h03);
    wr(8'h8C, 32'h1FF);

    // R6 wrong byte, then ignored bytes in error state
    wr(8'h0C, 32'h40);
    wr(8'h44, 32'h05);
    rd(8'h8C, v); check("R6 error flag", v, 32'h004);
    wr(8'h44, 32'h05); wr(8'h44, 32'h50);
    repeat (30) @(negedge clk);
    rd(8'h80, v); check("R6 ignored in error", v, 32'h03);

    // R5 restart from error
    cmd_up();
    repeat (40) @(negedge clk);
    rd(8'h80, v); check("R5 restart from error", v, 32'h43);
    wr(8'h8C, 32'h1FF);

    // R5 restart partway through a sequence
    wr(8'h0C, 32'h04);
    wr(8'h44, 32'hFF); wr(8'h44, 32'h0A);
    cmd_up();
    repeat (40) @(negedge clk);
    rd(8'h80, v); check("R5 mid-sequence restart mode", v, 32'h47);
    rd(8'h8C, v); check("R5 no error on restart", v, 32'h001);
    wr(8'h8C, 32'h1FF);

    // R8 power-good timeout
    stuck[3] = 1;
    wr(8'h0C, 32'h08);
    cmd_up();
    repeat (80) @(negedge clk);
    rd(8'h80, v); check("R8 mode unchanged", v, 32'h47);
    check("R8 enable restored", {25'd0, pwr_en}, 32'h47);
    rd(8'h8C, v); check("R8 timeout flag", v, 32'h009);
    wr(8'h8C, 32'h1FF);
    stuck[3] = 0;

    // R10 command while busy
    wr(8'h0C, 32'h38);
    cmd_up();
    cmd_dn();
    repeat (80) @(negedge clk);
    rd(8'h80, v); check("R10 busy command ignored", v, 32'h7F);
    rd(8'h8C, v); check("R10 busy flag", v, 32'h005);

    // R12 interrupt masking
    check("R12 all masked", {31'd0, irq}, 32'h0);
    wr(8'h48, 32'h1FE);
    @(negedge clk);
    check("R12 done unmasked", {31'd0, irq}, 32'h1);
    wr(8'h8C, 32'h001);
    @(negedge clk);
    check("R12 only masked left", {31'd0, irq}, 32'h0);
    wr(8'h48, 32'h000);
    @(negedge clk);
    check("R12 bit2 unmasked", {31'd0, irq}, 32'h1);
    wr(8'h8C, 32'h1FF);
    @(negedge clk);
    check("R12 cleared", {31'd0, irq}, 32'h0);
    rd(8'h8C, v); check("R11 status empty", v, 32'h0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule